// File: doc/BRIEF.md
# Packet Length and Gap Statistics Accumulator

This block collects running statistics over a stream of packet events. Each event carries a packet length and a 64-bit arrival timestamp counted in 10 ns ticks. For lengths it keeps a packet count, a length total, a sum of squared lengths, and the smallest and largest length. For the gaps between consecutive packets it keeps the same five quantities. Host software divides and subtracts these values to obtain mean length, average data rate, length variance, flow duration, mean gap and gap variance. Only one statistics set exists.

Events arrive through a valid/ready handshake, at up to one per cycle. Squares are produced by a two-stage pipeline, so an accepted event reaches the accumulators two clock edges after it is accepted. A clear input returns every accumulator to its empty state and drops events still in the pipeline. A snapshot input copies all ten accumulators at once into a shadow set, which is what the host reads.

Top module: `pkt_stats`

## Requirements
- R1: After reset or clear, every count, total and sum of squares is zero, both minimums are all ones and both maximums are zero; after reset the shadow outputs hold these same values.
- R2: Each accepted event adds one to the length count, adds its length to a 48-bit wrapping length total and adds its squared length to a 64-bit wrapping sum of squares.
- R3: The length minimum and maximum track the smallest and largest length accepted since the last clear.
- R4: The gap of an event is its timestamp minus the timestamp of the previous accepted event; the first event after reset or clear records no gap, so the gap count is one less than the length count whenever that is nonzero.
- R5: Each gap adds one to the gap count, adds to the gap total and adds its square to the gap sum of squares, and updates the gap minimum and maximum.
- R6: A timestamp difference of 2^32 ticks or more is limited to 2^32-1 before it is used anywhere.
- R7: The gap total and gap sum of squares stop at all ones instead of wrapping.
- R8: `ev_ready` is low in exactly the cycles where `clr` is high; an event held valid through a clear is accepted in the next cycle, as the first event after the clear; with `clr` low, events are accepted on consecutive cycles.
- R9: A clear discards any event accepted on either of the two edges before the clear edge.
- R10: The shadow outputs change only on an edge where `snap` is high, and then take the accumulator values from before that edge, including when `clr` is high on the same edge.
- R11: An event accepted on edge E is absent from a snapshot taken on edge E+2 and present in one taken on edge E+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Packet event present |
| ev_ready | output | 1 | Event can be accepted this cycle |
| ev_len | input | LEN_W | Packet length |
| ev_ts | input | TS_W | Arrival time in 10 ns ticks |
| clr | input | 1 | Clear all accumulators and the pipeline |
| snap | input | 1 | Copy accumulators into the shadow outputs |
| sh_lcnt | output | CNT_W | Shadow packet count |
| sh_lsum | output | LSUM_W | Shadow length total |
| sh_lsq | output | LSQ_W | Shadow sum of squared lengths |
| sh_lmin | output | LEN_W | Shadow minimum length |
| sh_lmax | output | LEN_W | Shadow maximum length |
| sh_icnt | output | CNT_W | Shadow gap count |
| sh_isum | output | ISUM_W | Shadow gap total |
| sh_isq | output | ISQ_W | Shadow sum of squared gaps |
| sh_imin | output | IVL_W | Shadow minimum gap |
| sh_imax | output | IVL_W | Shadow maximum gap |

## Verification
The hardest state to reach is saturation of the gap total, which at full width would need about 2^32 maximal gaps. The bench narrows that accumulator to 40 bits through its parameter and spaces 258 events by 2^33 ticks, so every gap is first limited to 2^32-1 and the total crosses its ceiling on the 257th gap. Discarding in-flight events is reached by raising clear exactly one cycle after two back-to-back events, while one sits in each pipeline stage.

// File: rtl/pkt_stats.sv
module pkt_stats #(
  parameter int LEN_W  = 16,
  parameter int TS_W   = 64,
  parameter int IVL_W  = 32,
  parameter int CNT_W  = 32,
  parameter int LSUM_W = 48,
  parameter int LSQ_W  = 64,
  parameter int ISUM_W = 64,
  parameter int ISQ_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  output logic              ev_ready,
  input  logic [LEN_W-1:0]  ev_len,
  input  logic [TS_W-1:0]   ev_ts,
  input  logic              clr,
  input  logic              snap,
  output logic [CNT_W-1:0]  sh_lcnt,
  output logic [LSUM_W-1:0] sh_lsum,
  output logic [LSQ_W-1:0]  sh_lsq,
  output logic [LEN_W-1:0]  sh_lmin,
  output logic [LEN_W-1:0]  sh_lmax,
  output logic [CNT_W-1:0]  sh_icnt,
  output logic [ISUM_W-1:0] sh_isum,
  output logic [ISQ_W-1:0]  sh_isq,
  output logic [IVL_W-1:0]  sh_imin,
  output logic [IVL_W-1:0]  sh_imax
);
  localparam int LSQ_P = 2 * LEN_W;
  localparam int ISQ_P = 2 * IVL_W;

  logic              accept;
  logic              have_prev;
  logic [TS_W-1:0]   prev_ts;
  logic [TS_W-1:0]   diff;
  logic [IVL_W-1:0]  ivl_in;

  logic              s1_v, s1_iv;
  logic [LEN_W-1:0]  s1_len;
  logic [IVL_W-1:0]  s1_ivl;
  logic              s2_v, s2_iv;
  logic [LEN_W-1:0]  s2_len;
  logic [IVL_W-1:0]  s2_ivl;
  logic [LSQ_P-1:0]  s2_lsq;
  logic [ISQ_P-1:0]  s2_isq;

  logic [CNT_W-1:0]  lcnt, icnt;
  logic [LSUM_W-1:0] lsum;
  logic [LSQ_W-1:0]  lsq;
  logic [LEN_W-1:0]  lmin, lmax;
  logic [ISUM_W-1:0] isum;
  logic [ISQ_W-1:0]  isq;
  logic [IVL_W-1:0]  imin, imax;

  logic [ISUM_W:0]   isum_t;
  logic [ISQ_W:0]    isq_t;

  assign ev_ready = ~clr;
  assign accept   = ev_valid & ev_ready;
  assign diff     = ev_ts - prev_ts;
  assign ivl_in   = (|diff[TS_W-1:IVL_W]) ? {IVL_W{1'b1}} : diff[IVL_W-1:0];
  assign isum_t   = {1'b0, isum} + (ISUM_W+1)'(s2_ivl);
  assign isq_t    = {1'b0, isq} + (ISQ_W+1)'(s2_isq);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      s1_v      <= 1'b0;
      s2_v      <= 1'b0;
      have_prev <= 1'b0;
    end else begin
      s1_v <= accept;
      s2_v <= s1_v;
      if (accept) have_prev <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_len  <= ev_len;
      s1_ivl  <= ivl_in;
      s1_iv   <= have_prev;
      prev_ts <= ev_ts;
    end
    s2_len <= s1_len;
    s2_ivl <= s1_ivl;
    s2_iv  <= s1_iv;
    s2_lsq <= LSQ_P'(s1_len) * LSQ_P'(s1_len);
    s2_isq <= ISQ_P'(s1_ivl) * ISQ_P'(s1_ivl);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      lcnt <= '0;
      lsum <= '0;
      lsq  <= '0;
      lmin <= '1;
      lmax <= '0;
      icnt <= '0;
      isum <= '0;
      isq  <= '0;
      imin <= '1;
      imax <= '0;
    end else if (s2_v) begin
      lcnt <= lcnt + 1'b1;
      lsum <= lsum + LSUM_W'(s2_len);
      lsq  <= lsq + LSQ_W'(s2_lsq);
      if (s2_len < lmin) lmin <= s2_len;
      if (s2_len > lmax) lmax <= s2_len;
      if (s2_iv) begin
        icnt <= icnt + 1'b1;
        isum <= isum_t[ISUM_W] ? {ISUM_W{1'b1}} : isum_t[ISUM_W-1:0];
        isq  <= isq_t[ISQ_W] ? {ISQ_W{1'b1}} : isq_t[ISQ_W-1:0];
        if (s2_ivl < imin) imin <= s2_ivl;
        if (s2_ivl > imax) imax <= s2_ivl;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_lcnt <= '0;
      sh_lsum <= '0;
      sh_lsq  <= '0;
      sh_lmin <= '1;
      sh_lmax <= '0;
      sh_icnt <= '0;
      sh_isum <= '0;
      sh_isq  <= '0;
      sh_imin <= '1;
      sh_imax <= '0;
    end else if (snap) begin
      sh_lcnt <= lcnt;
      sh_lsum <= lsum;
      sh_lsq  <= lsq;
      sh_lmin <= lmin;
      sh_lmax <= lmax;
      sh_icnt <= icnt;
      sh_isum <= isum;
      sh_isq  <= isq;
      sh_imin <= imin;
      sh_imax <= imax;
    end
  end

  AST_LMIN_LE_LMAX: assert property (@(posedge clk) disable iff (!rst_n)
    (lcnt != '0) |-> (lmin <= lmax)); // R3
  AST_IMIN_LE_IMAX: assert property (@(posedge clk) disable iff (!rst_n)
    (icnt != '0) |-> (imin <= imax)); // R5
  AST_GAP_COUNT_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    (lcnt != '0) |-> (icnt == lcnt - 1'b1)); // R4
  AST_NO_GAP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (lcnt == '0) |-> (icnt == '0)); // R4
  AST_GAP_SUM_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (isum >= $past(isum))); // R7
  AST_GAP_SQ_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (isq >= $past(isq))); // R7
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(snap) |-> ($stable(sh_lcnt) && $stable(sh_isum) && $stable(sh_lmin))); // R10
endmodule

// File: tb/pkt_stats_test.sv
module pkt_stats_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_valid = 1'b0;
  logic        ev_ready;
  logic [15:0] ev_len = '0;
  logic [63:0] ev_ts = '0;
  logic        clr = 1'b0;
  logic        snap = 1'b0;
  logic [31:0] sh_lcnt, sh_icnt;
  logic [47:0] sh_lsum;
  logic [63:0] sh_lsq;
  logic [15:0] sh_lmin, sh_lmax;
  logic [39:0] sh_isum;
  logic [63:0] sh_isq;
  logic [31:0] sh_imin, sh_imax;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] m_lcnt, m_icnt;
  logic [47:0] m_lsum;
  logic [63:0] m_lsq;
  logic [15:0] m_lmin, m_lmax;
  logic [39:0] m_isum;
  logic [63:0] m_isq;
  logic [31:0] m_imin, m_imax;
  logic [63:0] m_prev;
  logic        m_have;

  always #10 clk = ~clk;

  pkt_stats #(.ISUM_W(40)) uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ready(ev_ready),
    .ev_len(ev_len), .ev_ts(ev_ts), .clr(clr), .snap(snap),
    .sh_lcnt(sh_lcnt), .sh_lsum(sh_lsum), .sh_lsq(sh_lsq),
    .sh_lmin(sh_lmin), .sh_lmax(sh_lmax), .sh_icnt(sh_icnt),
    .sh_isum(sh_isum), .sh_isq(sh_isq), .sh_imin(sh_imin), .sh_imax(sh_imax)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic m_clear();
    m_lcnt = '0; m_lsum = '0; m_lsq = '0; m_lmin = '1; m_lmax = '0;
    m_icnt = '0; m_isum = '0; m_isq = '0; m_imin = '1; m_imax = '0;
    m_have = 1'b0; m_prev = '0;
  endtask

  task automatic m_add(logic [15:0] len, logic [63:0] ts);
    logic [63:0] d;
    logic [31:0] iv;
    logic [40:0] t1;
    logic [64:0] t2;
    m_lcnt = m_lcnt + 1;
    m_lsum = m_lsum + 48'(len);
    m_lsq  = m_lsq + 64'(len) * 64'(len);
    if (len < m_lmin) m_lmin = len;
    if (len > m_lmax) m_lmax = len;
    if (m_have) begin
      d  = ts - m_prev;
      iv = (d >= 64'h1_0000_0000) ? 32'hFFFF_FFFF : d[31:0];
      m_icnt = m_icnt + 1;
      t1 = {1'b0, m_isum} + 41'(iv);
      m_isum = t1[40] ? '1 : t1[39:0];
      t2 = {1'b0, m_isq} + 65'(64'(iv) * 64'(iv));
      m_isq = t2[64] ? '1 : t2[63:0];
      if (iv < m_imin) m_imin = iv;
      if (iv > m_imax) m_imax = iv;
    end
    m_prev = ts;
    m_have = 1'b1;
  endtask

  task automatic send(logic [15:0] len, logic [63:0] ts);
    ev_valid = 1'b1; ev_len = len; ev_ts = ts;
    @(negedge clk);
    m_add(len, ts);
  endtask

  task automatic idle();
    ev_valid = 1'b0;
  endtask

  task automatic do_clear();
    idle();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_clear();
  endtask

  task automatic compare(string tag);
    chk({tag, " R2 lcnt"}, 64'(sh_lcnt), 64'(m_lcnt));
    chk({tag, " R2 lsum"}, 64'(sh_lsum), 64'(m_lsum));
    chk({tag, " R2 lsq"},  sh_lsq, m_lsq);
    chk({tag, " R3 lmin"}, 64'(sh_lmin), 64'(m_lmin));
    chk({tag, " R3 lmax"}, 64'(sh_lmax), 64'(m_lmax));
    chk({tag, " R4 icnt"}, 64'(sh_icnt), 64'(m_icnt));
    chk({tag, " R5 isum"}, 64'(sh_isum), 64'(m_isum));
    chk({tag, " R5 isq"},  sh_isq, m_isq);
    chk({tag, " R5 imin"}, 64'(sh_imin), 64'(m_imin));
    chk({tag, " R5 imax"}, 64'(sh_imax), 64'(m_imax));
  endtask

  task automatic drain_snap(string tag);
    idle();
    repeat (3) @(negedge clk);
    snap = 1'b1;
    @(negedge clk);
    snap = 1'b0;
    compare(tag);
  endtask

  task automatic t_reset();
    m_clear();
    compare("reset R1 shadow");
    drain_snap("reset R1 snap");
  endtask

  task automatic t_basic();
    do_clear();
    send(16'd64, 64'd1000);
    idle(); @(negedge clk);
    send(16'd1500, 64'd1250);
    idle(); repeat (2) @(negedge clk);
    send(16'd40, 64'd1260);
    send(16'd9000, 64'd2000);
    send(16'd300, 64'd2003);
    drain_snap("basic R2 R3 R4 R5");
  endtask

  task automatic t_first_after_clear();
    do_clear();
    send(16'd77, 64'd5000);
    drain_snap("first R4 R1");
  endtask

  task automatic t_back_to_back();
    do_clear();
    for (int i = 0; i < 20; i++) begin
      ev_valid = 1'b1; ev_len = 16'(100 + i * 37); ev_ts = 64'(7000 + i * i);
      #1;
      chk("R8 ready streaming", 64'(ev_ready), 64'd1);
      @(negedge clk);
      m_add(16'(100 + i * 37), 64'(7000 + i * i));
    end
    drain_snap("streaming R8");
  endtask

  task automatic t_clamp();
    do_clear();
    send(16'd1, 64'd10);
    send(16'd2, 64'd10 + 64'h100_0000_0000);
    send(16'd3, 64'd10 + 64'h100_0000_0000 + 64'hFFFF_FFFF);
    drain_snap("clamp R6");
    chk("R6 imax clamped", 64'(sh_imax), 64'hFFFF_FFFF);
  endtask

  task automatic t_sat();
    logic [63:0] ts = 64'd0;
    do_clear();
    send(16'd5, 64'd0);
    send(16'd5, 64'hFFFF_FFFF);
    drain_snap("sq-sat R7 one gap");
    send(16'd5, 64'h1_FFFF_FFFE);
    drain_snap("sq-sat R7");
    chk("R7 isq saturated", sh_isq, 64'hFFFF_FFFF_FFFF_FFFF);
    do_clear();
    for (int i = 0; i < 258; i++) begin
      send(16'd1, ts);
      ts = ts + 64'h2_0000_0000;
    end
    drain_snap("sum-sat R7");
    chk("R7 isum saturated", 64'(sh_isum), 64'hFF_FFFF_FFFF);
  endtask

  task automatic t_clear_hold();
    do_clear();
    send(16'd10, 64'd100);
    send(16'd20, 64'd200);
    drain_snap("pre-hold R8");
    ev_valid = 1'b1; ev_len = 16'd33; ev_ts = 64'd900;
    clr = 1'b1;
    #1;
    chk("R8 ready low in clear", 64'(ev_ready), 64'd0);
    @(negedge clk);
    clr = 1'b0;
    m_clear();
    #1;
    chk("R8 ready back after clear", 64'(ev_ready), 64'd1);
    @(negedge clk);
    m_add(16'd33, 64'd900);
    drain_snap("held R8");
  endtask

  task automatic t_flush();
    do_clear();
    send(16'd11, 64'd100);
    send(16'd22, 64'd300);
    idle();
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    m_clear();
    drain_snap("flush R9");
    send(16'd44, 64'd400);
    drain_snap("flush R9 next first");
  endtask

  task automatic t_snap();
    logic [31:0] c0;
    do_clear();
    send(16'd50, 64'd10);
    send(16'd60, 64'd30);
    drain_snap("snap R10 base");
    c0 = sh_lcnt;
    send(16'd70, 64'd90);
    idle(); repeat (4) @(negedge clk);
    chk("R10 shadow held without snap", 64'(sh_lcnt), 64'(c0));
    snap = 1'b1; clr = 1'b1;
    @(negedge clk);
    snap = 1'b0; clr = 1'b0;
    compare("snap+clr R10");
    m_clear();
    drain_snap("after snap+clr R10 R1");
  endtask

  task automatic t_latency();
    do_clear();
    repeat (2) @(negedge clk);
    drain_snap("latency base R11");
    send(16'd123, 64'd50);
    idle();
    @(negedge clk);
    snap = 1'b1;
    @(negedge clk);
    chk("R11 absent at E+2", 64'(sh_lcnt), 64'd0);
    @(negedge clk);
    snap = 1'b0;
    chk("R11 present at E+3", 64'(sh_lcnt), 64'd1);
    chk("R11 length at E+3", 64'(sh_lsum), 64'd123);
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_first_after_clear();
    t_back_to_back();
    t_clamp();
    t_sat();
    t_clear_hold();
    t_flush();
    t_snap();
    t_latency();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule